// File: doc/BRIEF.md
# Bank-Switched Memory Address Decoder

This block sits between the processor bus of an 8-bit system with a 16-bit address space and its memories. Each cycle it turns the address and the memory-versus-I/O cycle qualifiers into one chip select and a card-local address. There are five targets: a 6 kB boot ROM, a 1 kB static RAM, a 4 kB video RAM, a 48 kB dynamic RAM card and an optional 16 kB RAM card. A control latch, written through I/O port 0x78, picks what the lowest 16 kB of the address space shows. In one state it shows the ROM, static RAM and video region. In the other it shows the 16 kB slice of the 48 kB card that is otherwise out of reach. The upper 48 kB decode never changes with the latch.

Software swaps the low window by writing the control port from code placed above 0x4000. It swaps back the same way before it calls any firmware. Reset always brings the ROM back into view, so the reset vector at 0x0000 is fetched from ROM. A static configuration input tells the block whether the 16 kB card is fitted. Without that card, the top 16 kB comes from the 48 kB card and the swap has no effect. Only the low byte of the address takes part in I/O port decoding.

Top module: `bank_mem_decoder`

## Requirements
- R1: After reset the latch is in the ROM-visible state: a memory access to 0x0000 selects the ROM with local address 0x0000, and an I/O read of port 0x78 returns 0x00.
- R2: In the ROM-visible state, 0x0000–0x17FF selects the ROM (local = address), 0x1800–0x1BFF selects the static RAM (local = address − 0x1800), and 0x3000–0x3FFF selects the video RAM (local = address − 0x3000).
- R3: In the ROM-visible state, addresses 0x1C00–0x2FFF select no device and the local address output is 0x0000.
- R4: In both latch states, with the 16 kB card fitted, 0x4000–0xBFFF selects the 48 kB card (local = address − 0x4000) and 0xC000–0xFFFF selects the 16 kB card (local = address − 0xC000).
- R5: In the swapped state, with the card fitted, every address 0x0000–0x3FFF selects the 48 kB card with local address = address + 0x8000. ROM, static RAM and video RAM are never selected.
- R6: Only bit 6 of the byte written to port 0x78 sets the latch (1 = swapped, 0 = ROM visible). For example 0x60 and 0x40 swap, while 0x20 and 0xBF restore.
- R7: The latch loads only on the first cycle in which the I/O write strobe is high during an I/O cycle addressed to port 0x78. A strobe held high over later cycles, and a write to any other port, leave the latch unchanged.
- R8: An I/O read of port 0x78 returns the latch value in bit 6, with all other bits 0. At any other port, and outside I/O reads, the read data output is 0x00.
- R9: At most one chip select is active at a time. No select is active during an I/O cycle or when no memory cycle is flagged, and the local address is 0x0000 whenever no select is active.
- R10: With the 16 kB card absent, 0xC000–0xFFFF selects the 48 kB card with local address = address − 0x4000. The low window then decodes as in the ROM-visible state whatever the latch holds.
- R11: A latch write takes effect on the memory cycle right after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| card_present_i | input | 1 | 1 when the 16 kB card is fitted |
| mem_i | input | 1 | Memory cycle in progress |
| io_i | input | 1 | I/O cycle in progress (suppresses memory selects) |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| addr_i | input | 16 | Processor address; low byte is the I/O port |
| data_i | input | 8 | Write data for I/O writes |
| rd_data_o | output | 8 | Read-back data of the control port |
| rom_cs_o | output | 1 | Boot ROM select |
| sram_cs_o | output | 1 | Static RAM select |
| vram_cs_o | output | 1 | Video RAM select |
| dram_cs_o | output | 1 | 48 kB card select |
| ext_cs_o | output | 1 | 16 kB card select |
| local_addr_o | output | 16 | Address within the selected device |

## Verification
The decode is probed at the first and last address of every region, in both latch states and with the 16 kB card fitted and absent. These probes separate an off-by-one boundary, a wrong base subtraction and a swap leaking into the upper 48 kB. The latch is driven with control bytes that differ outside bit 6, with writes to a neighbouring port and with a strobe held high while the data changes. These show whether the latch listens to one bit, one port and one edge. A memory access placed right after each write checks that the new mapping applies from the next cycle.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_ROM  = 3'd1,
    RG_SRAM = 3'd2,
    RG_VRAM = 3'd3,
    RG_DRAM = 3'd4,
    RG_EXT  = 3'd5
  } region_e;

  localparam int unsigned N_CS = 5;
endpackage

// File: rtl/bmd_bank_latch.sv
module bmd_bank_latch #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] CTRL_PORT = 8'h78,
  parameter int unsigned SWAP_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              swap_q_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic wr_q;
  logic port_hit;
  logic load;
  logic unused_bits;

  assign port_hit = (addr_i[PORT_W-1:0] == CTRL_PORT);
  // edge of the strobe, not its level
  assign load = io_i && io_wr_i && !wr_q && port_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= 1'b0;
      swap_q_o <= 1'b0;
    end else begin
      wr_q <= io_wr_i;
      if (load) swap_q_o <= data_i[SWAP_BIT];
    end
  end

  assign rd_data_o = (io_i && io_rd_i && port_hit) ?
                     (DATA_W'(swap_q_o) << SWAP_BIT) : '0;

  assign unused_bits = ^{data_i, addr_i[ADDR_W-1:PORT_W]};
endmodule

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
  import bmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 16'h1800,
  parameter logic [ADDR_W-1:0] GAP_BASE  = 16'h1C00,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h3000,
  parameter logic [ADDR_W-1:0] WIN_TOP   = 16'h4000,
  parameter logic [ADDR_W-1:0] EXT_BASE  = 16'hC000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              swap_i,
  input  logic              card_i,
  output region_e           region_o,
  output logic [ADDR_W-1:0] local_o
);
  // hidden slice sits right after the linear part of the 48 kB card
  localparam logic [ADDR_W-1:0] HIDDEN_OFS = EXT_BASE - WIN_TOP;

  always_comb begin
    region_o = RG_NONE;
    local_o  = '0;
    if (addr_i < WIN_TOP) begin
      if (swap_i) begin
        region_o = RG_DRAM;
        local_o  = addr_i + HIDDEN_OFS;
      end else if (addr_i < SRAM_BASE) begin
        region_o = RG_ROM;
        local_o  = addr_i;
      end else if (addr_i < GAP_BASE) begin
        region_o = RG_SRAM;
        local_o  = addr_i - SRAM_BASE;
      end else if (addr_i >= VRAM_BASE) begin
        region_o = RG_VRAM;
        local_o  = addr_i - VRAM_BASE;
      end
    end else if (addr_i < EXT_BASE || !card_i) begin
      region_o = RG_DRAM;
      local_o  = addr_i - WIN_TOP;
    end else begin
      region_o = RG_EXT;
      local_o  = addr_i - EXT_BASE;
    end
  end
endmodule

// File: rtl/bmd_select.sv
module bmd_select
  import bmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              mem_i,
  input  logic              io_i,
  input  region_e           region_i,
  input  logic [ADDR_W-1:0] local_i,
  output logic [N_CS-1:0]   cs_o,
  output logic [ADDR_W-1:0] local_o
);
  logic act;
  assign act = mem_i && !io_i;

  for (genvar i = 0; i < N_CS; i++) begin : g_cs
    assign cs_o[i] = act && (region_i == region_e'(3'(i + 1)));
  end

  assign local_o = (|cs_o) ? local_i : '0;
endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import bmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PORT_W   = 8,
  parameter logic [PORT_W-1:0] CTRL_PORT = 8'h78,
  parameter int unsigned SWAP_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_present_i,
  input  logic              mem_i,
  input  logic              io_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rom_cs_o,
  output logic              sram_cs_o,
  output logic              vram_cs_o,
  output logic              dram_cs_o,
  output logic              ext_cs_o,
  output logic [ADDR_W-1:0] local_addr_o
);
  logic              swap_q;
  logic              swap_eff;
  region_e           region;
  logic [ADDR_W-1:0] local_raw;
  logic [N_CS-1:0]   cs;

  bmd_bank_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
    .CTRL_PORT(CTRL_PORT), .SWAP_BIT(SWAP_BIT)
  ) i_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .io_i     (io_i),
    .io_wr_i  (io_wr_i),
    .io_rd_i  (io_rd_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .swap_q_o (swap_q),
    .rd_data_o(rd_data_o)
  );

  // swap needs the extra card to back the upper window
  assign swap_eff = swap_q && card_present_i;

  bmd_region_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr_i  (addr_i),
    .swap_i  (swap_eff),
    .card_i  (card_present_i),
    .region_o(region),
    .local_o (local_raw)
  );

  bmd_select #(.ADDR_W(ADDR_W)) i_select (
    .mem_i   (mem_i),
    .io_i    (io_i),
    .region_i(region),
    .local_i (local_raw),
    .cs_o    (cs),
    .local_o (local_addr_o)
  );

  assign rom_cs_o  = cs[0];
  assign sram_cs_o = cs[1];
  assign vram_cs_o = cs[2];
  assign dram_cs_o = cs[3];
  assign ext_cs_o  = cs[4];
endmodule

// File: rtl/bmd_chk.sv
module bmd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        card_present_i,
  input logic        mem_i,
  input logic        io_i,
  input logic        io_wr_i,
  input logic [15:0] addr_i,
  input logic [7:0]  data_i,
  input logic        rom_cs_o,
  input logic        sram_cs_o,
  input logic        vram_cs_o,
  input logic        dram_cs_o,
  input logic        ext_cs_o,
  input logic [15:0] local_addr_o,
  input logic        swap_q
);
  logic wr_prev;
  logic fire;
  logic acc;
  logic [4:0] sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_prev <= 1'b0;
    else         wr_prev <= io_wr_i;
  end

  assign fire = io_i && io_wr_i && !wr_prev && (addr_i[7:0] == 8'h78);
  assign acc  = mem_i && !io_i;
  assign sel  = {ext_cs_o, dram_cs_o, vram_cs_o, sram_cs_o, rom_cs_o};

  // R9
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  // R9
  io_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> (sel == 5'b0 && local_addr_o == 16'h0));

  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(swap_q));

  // R6
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (swap_q == $past(data_i[6])));

  // R4
  mid_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && addr_i >= 16'h4000 && addr_i < 16'hC000)
      |-> (dram_cs_o && local_addr_o == addr_i - 16'h4000));

  // R5
  swap_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && swap_q && card_present_i && addr_i < 16'h4000)
      |-> (dram_cs_o && local_addr_o == addr_i + 16'h8000));

  // R10
  noext_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !card_present_i && addr_i >= 16'hC000)
      |-> (dram_cs_o && !ext_cs_o && local_addr_o == addr_i - 16'h4000));
endmodule

bind bank_mem_decoder bmd_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .card_present_i(card_present_i),
  .mem_i         (mem_i),
  .io_i          (io_i),
  .io_wr_i       (io_wr_i),
  .addr_i        (addr_i),
  .data_i        (data_i),
  .rom_cs_o      (rom_cs_o),
  .sram_cs_o     (sram_cs_o),
  .vram_cs_o     (vram_cs_o),
  .dram_cs_o     (dram_cs_o),
  .ext_cs_o      (ext_cs_o),
  .local_addr_o  (local_addr_o),
  .swap_q        (swap_q)
);

// File: tb/test_bank_mem_decoder.sv
module test_bank_mem_decoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        card = 1'b1;
  logic        mem = 1'b0, io = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [7:0]  rdata;
  logic        rom_cs, sram_cs, vram_cs, dram_cs, ext_cs;
  logic [15:0] loc;

  bank_mem_decoder i_bank_mem_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .card_present_i(card),
    .mem_i(mem), .io_i(io), .io_wr_i(wr), .io_rd_i(rd),
    .addr_i(addr), .data_i(data), .rd_data_o(rdata),
    .rom_cs_o(rom_cs), .sram_cs_o(sram_cs), .vram_cs_o(vram_cs),
    .dram_cs_o(dram_cs), .ext_cs_o(ext_cs), .local_addr_o(loc)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [4:0]  cs;   // {ext,dram,vram,sram,rom}
    logic [15:0] la;
    logic [7:0]  rd;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit m_swap = 1'b0;
  bit done = 1'b0;

  function automatic item_t model(input logic [15:0] a, input logic mc,
                                  input logic ic, input logic rc, input string tag);
    item_t it;
    it.cs = '0; it.la = '0; it.rd = '0; it.tag = tag;
    if (ic && rc && a[7:0] == 8'h78) it.rd = m_swap ? 8'h40 : 8'h00;
    if (mc && !ic) begin
      if (a < 16'h4000) begin
        if (m_swap && card) begin it.cs = 5'b01000; it.la = a + 16'h8000; end
        else if (a < 16'h1800) begin it.cs = 5'b00001; it.la = a; end
        else if (a < 16'h1C00) begin it.cs = 5'b00010; it.la = a - 16'h1800; end
        else if (a >= 16'h3000) begin it.cs = 5'b00100; it.la = a - 16'h3000; end
      end else if (a < 16'hC000 || !card) begin
        it.cs = 5'b01000; it.la = a - 16'h4000;
      end else begin
        it.cs = 5'b10000; it.la = a - 16'hC000;
      end
    end
    return it;
  endfunction

  task automatic mem_acc(input logic [15:0] a, input string tag);
    @(negedge clk);
    mem = 1'b1; io = 1'b0; wr = 1'b0; rd = 1'b0; addr = a;
    q.push_back(model(a, 1'b1, 1'b0, 1'b0, tag));
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    mem = 1'b0; io = 1'b0; wr = 1'b0; rd = 1'b0; addr = 16'h0;
    q.push_back(model(16'h0, 1'b0, 1'b0, 1'b0, tag));
  endtask

  task automatic io_rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    mem = 1'b0; io = 1'b1; wr = 1'b0; rd = 1'b1; addr = a;
    q.push_back(model(a, 1'b0, 1'b1, 1'b1, tag));
  endtask

  // strobe must be low in the previous cycle (every other task drops it)
  task automatic io_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    mem = 1'b0; io = 1'b1; wr = 1'b1; rd = 1'b0; addr = a; data = d;
    q.push_back(model(a, 1'b0, 1'b1, 1'b0, tag));
    if (a[7:0] == 8'h78) m_swap = d[6];
  endtask

  task automatic set_card(input logic v);
    @(negedge clk);
    card = v; mem = 1'b0; io = 1'b0; wr = 1'b0; rd = 1'b0;
  endtask

  // monitor: compare each pushed item mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        item_t e;
        logic [4:0] got;
        e = q.pop_front();
        got = {ext_cs, dram_cs, vram_cs, sram_cs, rom_cs};
        n_chk++;
        if (got !== e.cs || loc !== e.la || rdata !== e.rd) begin
          n_bad++;
          $display("FAIL %s: cs=%b la=%h rd=%h expected cs=%b la=%h rd=%h",
                   e.tag, got, loc, rdata, e.cs, e.la, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1
    mem_acc(16'h0000, "R1 reset rom");
    io_rd(16'h0078, "R1 R8 reset readback");
    // R2
    mem_acc(16'h17FF, "R2 rom top");
    mem_acc(16'h1800, "R2 sram base");
    mem_acc(16'h1BFF, "R2 sram top");
    mem_acc(16'h3000, "R2 vram base");
    mem_acc(16'h3FFF, "R2 vram top");
    // R3
    mem_acc(16'h1C00, "R3 gap low");
    mem_acc(16'h2FFF, "R3 gap high");
    // R4
    mem_acc(16'h4000, "R4 dram base");
    mem_acc(16'hBFFF, "R4 dram top");
    mem_acc(16'hC000, "R4 ext base");
    mem_acc(16'hFFFF, "R4 ext top");
    // R9
    idle("R9 idle no select");
    io_rd(16'h1234, "R9 R8 io read other port");
    // R7
    io_wr(16'h0079, 8'h60, "R7 other port");
    mem_acc(16'h0000, "R7 other port ignored");
    // R5 / R11
    io_wr(16'h0078, 8'h60, "R5 write swap");
    mem_acc(16'h0000, "R11 next cycle swapped");
    mem_acc(16'h3FFF, "R5 window top");
    mem_acc(16'h1800, "R5 sram hidden");
    mem_acc(16'h4000, "R4 swapped dram base");
    mem_acc(16'hC000, "R4 swapped ext base");
    io_rd(16'h0078, "R8 readback swapped");
    // R6
    io_wr(16'h0078, 8'hBF, "R6 write BF");
    mem_acc(16'h1800, "R6 BF restores");
    io_wr(16'h0078, 8'h40, "R6 write 40");
    mem_acc(16'h0000, "R6 40 swaps");
    io_wr(16'h0078, 8'h20, "R6 write 20");
    mem_acc(16'h3000, "R6 20 restores");
    // R7 held strobe: second data beat must not load
    io_wr(16'h0078, 8'h60, "R7 first edge");
    @(negedge clk);
    data = 8'h20;
    q.push_back(model(16'h0078, 1'b0, 1'b1, 1'b0, "R7 held strobe"));
    mem_acc(16'h0000, "R7 held strobe ignored");
    // R10
    set_card(1'b0);
    mem_acc(16'h0000, "R10 swap disabled");
    mem_acc(16'hC000, "R10 top from dram");
    mem_acc(16'hFFFF, "R10 top end");
    io_rd(16'h0078, "R10 R8 latch kept");
    set_card(1'b1);
    mem_acc(16'h0000, "R10 card back swapped");
    io_wr(16'h0078, 8'h20, "R6 restore");
    mem_acc(16'h0000, "R6 rom again");
    idle("R9 final idle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule